// File: doc/BRIEF.md
# Block-Buffered Cartridge-to-RAM Copy Engine

This engine moves a run of bytes from a cartridge ROM, which can only be read as 16-bit halfwords, into a byte-addressed RAM. A single `start_i` pulse supplies the source cartridge address, the destination RAM address and the length, written as byte count minus one. The engine then works through the transfer in blocks. Each block is first read from ROM into a 128-byte staging buffer. The buffer is then written out to RAM one byte per handshake. The cartridge and RAM address registers advance after each block. `done_o` pulses for one cycle when the last block has been written.

The first block follows the rules of the hardware it models, including that hardware's flaws. The first block is shortened so that the RAM address becomes 8-byte aligned afterwards. Its write length gets an off-by-one increase in one case. Its write length is also cut by the RAM misalignment, so some fetched bytes are never written and a gap is left in RAM. After every block the remaining length is rounded up to even.

Both data ports use valid/ready handshakes. Once the engine raises `rom_req_valid` or `ram_wr_valid`, it holds the valid signal, the address and (for RAM) the data unchanged until the matching ready is seen high on a clock edge. Only one ROM read is ever outstanding. The ROM answers it with a one-cycle `rom_rsp_valid` pulse, and the engine accepts that pulse in any cycle it arrives.

Top module: `cartdma_top`

## Requirements
- R1: On `start_i` while idle, the engine loads both addresses with bit 0 cleared and the remaining length as `len_m1_i + 1`, and raises `busy_o` on the next cycle. While `busy_o` is high, including the cycle in which `done_o` is high, `start_i` is ignored.
- R2: Every block takes `min(remaining, 128 - (RAM address mod 8))` bytes, where the RAM address is the value at the start of that block.
- R3: After a block is taken, its size is subtracted from the remaining length, and an odd result is increased by one.
- R4: Each block is read as halfwords from consecutive even cartridge addresses. The number of bytes fetched is the block size rounded up to even, and the cartridge address advances by that amount. The byte at the even address is bits [15:8] of a response and the next byte is bits [7:0]. Buffer byte i is written to RAM address + i.
- R5: In the first block only, if the block size equals `128 - misalign - 1`, the write length is one greater than the block size.
- R6: In the first block only, the write length (after R5) is reduced by the misalignment and clamped at zero. The bytes that are left out are never written. Later blocks write exactly their block size.
- R7: After each block, the RAM address advances by the write length and is then rounded up to a multiple of 8.
- R8: Cartridge bytes at or above `ROM_BYTES` read as 0xFF. A halfword whose even address is at or above `ROM_BYTES` is not requested from the ROM port.
- R9: `wr_len_rb_o` resets to 0x7F. When a transfer completes, it becomes 0x7F for lengths above 8 bytes, or `0x7F - (start RAM address mod 8)` for lengths of 8 bytes or fewer.
- R10: `done_o` is high for exactly one cycle after the last RAM write, with the final addresses on `cart_addr_o` and `ram_addr_o`. `busy_o` falls on the next cycle.
- R11: When valid is high and ready is low on either data port, the engine holds valid, the address and the data unchanged on the next cycle. The RAM receives exactly one write per byte to be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin a transfer (taken only when idle) |
| cart_addr_i | input | CART_AW | Starting cartridge byte address |
| ram_addr_i | input | RAM_AW | Starting RAM byte address |
| len_m1_i | input | LEN_W | Transfer length in bytes minus one |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cart_addr_o | output | CART_AW | Current cartridge address register |
| ram_addr_o | output | RAM_AW | Current RAM address register |
| wr_len_rb_o | output | 8 | Length register readback |
| rom_req_valid | output | 1 | Halfword read request |
| rom_req_ready | input | 1 | ROM accepts the request |
| rom_req_addr | output | CART_AW | Even cartridge address of the halfword |
| rom_rsp_valid | input | 1 | Halfword read data is present |
| rom_rsp_data | input | 16 | Halfword read data |
| ram_wr_valid | output | 1 | Byte write request |
| ram_wr_ready | input | 1 | RAM accepts the write |
| ram_wr_addr | output | RAM_AW | RAM byte address |
| ram_wr_data | output | 8 | Byte to write |

## Verification
Two events can fall in the same cycle. The first is the completion pulse and a fresh `start_i`: because the engine is still busy in the `done_o` cycle, a start presented in that exact cycle must be dropped. The bench waits for `done_o`, drives `start_i` with different parameters in that same cycle, and then checks that the engine is idle with the address outputs unchanged. The second is back-pressure arriving while a request is pending. Ready is withheld at random on both ports. The bench then checks that every RAM byte is written once with the right value, and checks the final address registers against a model computed from the requirements.

// File: rtl/cartdma_pkg.sv
package cartdma_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PLAN, S_FETCH, S_WRITE, S_NEXT, S_DONE
  } eng_state_t;

  typedef enum logic [1:0] {
    F_IDLE, F_REQ, F_WAIT
  } fetch_state_t;
endpackage

// File: rtl/cartdma_block_calc.sv
module cartdma_block_calc #(
  parameter int BLK   = 128,
  parameter int LEN_W = 24,
  localparam int BW   = $clog2(BLK) + 1
) (
  input  logic [2:0]     mis_i,
  input  logic [LEN_W:0] rem_i,
  input  logic           first_i,
  output logic [BW-1:0]  fetch_o,
  output logic [BW-1:0]  wr_o,
  output logic [LEN_W:0] rem_o
);
  logic [BW-1:0]  blk_len, take, adj;
  logic [LEN_W:0] rem_after;

  always_comb begin
    blk_len   = BW'(BLK) - BW'(mis_i);
    take      = (rem_i < (LEN_W+1)'(blk_len)) ? rem_i[BW-1:0] : blk_len;
    rem_after = rem_i - (LEN_W+1)'(take);
    rem_o     = rem_after + (LEN_W+1)'(rem_after[0]);
    fetch_o   = take + BW'(take[0]);
    // first block: off-by-one round-up, then the misalignment cut
    adj       = (take == blk_len - BW'(1)) ? take + BW'(1) : take;
    if (!first_i)                wr_o = take;
    else if (adj > BW'(mis_i))   wr_o = adj - BW'(mis_i);
    else                         wr_o = '0;
  end
endmodule

// File: rtl/cartdma_buf.sv
module cartdma_buf #(
  parameter int BLK  = 128,
  localparam int HIW = $clog2(BLK/2),
  localparam int BIW = $clog2(BLK)
) (
  input  logic           clk,
  input  logic           we_i,
  input  logic [HIW-1:0] hw_idx_i,
  input  logic [15:0]    hw_data_i,
  input  logic [BIW-1:0] rd_idx_i,
  output logic [7:0]     rd_data_o
);
  logic [7:0] mem [BLK];

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[{hw_idx_i, 1'b0}] <= hw_data_i[15:8];
      mem[{hw_idx_i, 1'b1}] <= hw_data_i[7:0];
    end
  end

  assign rd_data_o = mem[rd_idx_i];
endmodule

// File: rtl/cartdma_fetch.sv
module cartdma_fetch
  import cartdma_pkg::*;
#(
  parameter int CART_AW = 32,
  parameter int BLK     = 128,
  parameter logic [CART_AW:0] ROM_BYTES = (CART_AW+1)'(32'h0100_0000),
  localparam int HIW    = $clog2(BLK/2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [CART_AW-1:0] base_i,
  input  logic [HIW:0]       nhw_i,
  output logic               done_o,
  output logic               rom_req_valid,
  input  logic               rom_req_ready,
  output logic [CART_AW-1:0] rom_req_addr,
  input  logic               rom_rsp_valid,
  input  logic [15:0]        rom_rsp_data,
  output logic               buf_we_o,
  output logic [HIW-1:0]     buf_idx_o,
  output logic [15:0]        buf_data_o
);
  fetch_state_t       st_q;
  logic [CART_AW-1:0] base_q, cur_addr;
  logic [HIW:0]       nhw_q, cnt_q;
  logic               oor_full, oor_low, step;

  always_comb begin
    cur_addr  = base_q + CART_AW'({cnt_q, 1'b0});
    oor_full  = {1'b0, cur_addr} >= ROM_BYTES;
    oor_low   = ({1'b0, cur_addr} + (CART_AW+1)'(1)) >= ROM_BYTES;
    rom_req_valid = (st_q == F_REQ) && !oor_full;
    rom_req_addr  = cur_addr;
    buf_idx_o     = cnt_q[HIW-1:0];
    buf_we_o      = 1'b0;
    buf_data_o    = 16'hFFFF;
    if (st_q == F_REQ && oor_full) begin
      buf_we_o = 1'b1;
    end else if (st_q == F_WAIT && rom_rsp_valid) begin
      buf_we_o   = 1'b1;
      buf_data_o = oor_low ? {rom_rsp_data[15:8], 8'hFF} : rom_rsp_data;
    end
    step   = buf_we_o;
    done_o = step && (cnt_q + (HIW+1)'(1) == nhw_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= F_IDLE;
      base_q <= '0;
      nhw_q  <= '0;
      cnt_q  <= '0;
    end else begin
      case (st_q)
        F_IDLE: if (start_i) begin
          base_q <= base_i;
          nhw_q  <= nhw_i;
          cnt_q  <= '0;
          st_q   <= F_REQ;
        end
        F_REQ: if (!oor_full && rom_req_ready) st_q <= F_WAIT;
        default: ;
      endcase
      if (step) begin
        cnt_q <= cnt_q + (HIW+1)'(1);
        st_q  <= done_o ? F_IDLE : F_REQ;
      end
    end
  end

  a_r11_rom_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req_valid && !rom_req_ready |=> rom_req_valid && $stable(rom_req_addr));
  a_r8_no_oor_request: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req_valid |-> ({1'b0, rom_req_addr} < ROM_BYTES));
  a_r4_even_request: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req_valid |-> !rom_req_addr[0]);
endmodule

// File: rtl/cartdma_top.sv
module cartdma_top
  import cartdma_pkg::*;
#(
  parameter int CART_AW = 32,
  parameter int RAM_AW  = 24,
  parameter int LEN_W   = 24,
  parameter int BLK     = 128,
  parameter logic [CART_AW:0] ROM_BYTES = (CART_AW+1)'(32'h0100_0000),
  localparam int BW     = $clog2(BLK) + 1,
  localparam int HIW    = $clog2(BLK/2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [CART_AW-1:0] cart_addr_i,
  input  logic [RAM_AW-1:0]  ram_addr_i,
  input  logic [LEN_W-1:0]   len_m1_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [CART_AW-1:0] cart_addr_o,
  output logic [RAM_AW-1:0]  ram_addr_o,
  output logic [7:0]         wr_len_rb_o,
  output logic               rom_req_valid,
  input  logic               rom_req_ready,
  output logic [CART_AW-1:0] rom_req_addr,
  input  logic               rom_rsp_valid,
  input  logic [15:0]        rom_rsp_data,
  output logic               ram_wr_valid,
  input  logic               ram_wr_ready,
  output logic [RAM_AW-1:0]  ram_wr_addr,
  output logic [7:0]         ram_wr_data
);
  eng_state_t         state_q;
  logic [CART_AW-1:0] cart_q;
  logic [RAM_AW-1:0]  ram_q;
  logic [LEN_W:0]     rem_q, calc_rem;
  logic               first_q, small_q;
  logic [2:0]         mis0_q;
  logic [BW-1:0]      fetch_q, wr_q, idx_q, calc_fetch, calc_wr;
  logic [7:0]         rb_q;
  logic               f_done, buf_we;
  logic [HIW-1:0]     buf_idx;
  logic [15:0]        buf_data;
  logic [RAM_AW-1:0]  ram_adv;

  cartdma_block_calc #(.BLK(BLK), .LEN_W(LEN_W)) i_calc (
    .mis_i(ram_q[2:0]), .rem_i(rem_q), .first_i(first_q),
    .fetch_o(calc_fetch), .wr_o(calc_wr), .rem_o(calc_rem)
  );

  cartdma_fetch #(.CART_AW(CART_AW), .BLK(BLK), .ROM_BYTES(ROM_BYTES)) i_fetch (
    .clk(clk), .rst_n(rst_n),
    .start_i(state_q == S_PLAN), .base_i(cart_q), .nhw_i(calc_fetch[BW-1:1]),
    .done_o(f_done),
    .rom_req_valid(rom_req_valid), .rom_req_ready(rom_req_ready),
    .rom_req_addr(rom_req_addr), .rom_rsp_valid(rom_rsp_valid),
    .rom_rsp_data(rom_rsp_data),
    .buf_we_o(buf_we), .buf_idx_o(buf_idx), .buf_data_o(buf_data)
  );

  cartdma_buf #(.BLK(BLK)) i_buf (
    .clk(clk), .we_i(buf_we), .hw_idx_i(buf_idx), .hw_data_i(buf_data),
    .rd_idx_i(idx_q[BW-2:0]), .rd_data_o(ram_wr_data)
  );

  assign ram_adv      = (ram_q + RAM_AW'(wr_q) + RAM_AW'(7)) & ~RAM_AW'(7);
  assign busy_o       = (state_q != S_IDLE);
  assign done_o       = (state_q == S_DONE);
  assign cart_addr_o  = cart_q;
  assign ram_addr_o   = ram_q;
  assign wr_len_rb_o  = rb_q;
  assign ram_wr_valid = (state_q == S_WRITE);
  assign ram_wr_addr  = ram_q + RAM_AW'(idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cart_q  <= '0;
      ram_q   <= '0;
      rem_q   <= '0;
      first_q <= 1'b0;
      small_q <= 1'b0;
      mis0_q  <= '0;
      fetch_q <= '0;
      wr_q    <= '0;
      idx_q   <= '0;
      rb_q    <= 8'h7F;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          cart_q  <= {cart_addr_i[CART_AW-1:1], 1'b0};
          ram_q   <= {ram_addr_i[RAM_AW-1:1], 1'b0};
          mis0_q  <= {ram_addr_i[2:1], 1'b0};
          rem_q   <= (LEN_W+1)'(len_m1_i) + (LEN_W+1)'(1);
          small_q <= (len_m1_i < LEN_W'(8));
          first_q <= 1'b1;
          state_q <= S_PLAN;
        end
        S_PLAN: begin
          fetch_q <= calc_fetch;
          wr_q    <= calc_wr;
          rem_q   <= calc_rem;
          state_q <= S_FETCH;
        end
        S_FETCH: if (f_done) begin
          cart_q  <= cart_q + CART_AW'(fetch_q);
          idx_q   <= '0;
          state_q <= (wr_q == '0) ? S_NEXT : S_WRITE;
        end
        S_WRITE: if (ram_wr_ready) begin
          if (idx_q == wr_q - BW'(1)) state_q <= S_NEXT;
          else                        idx_q   <= idx_q + BW'(1);
        end
        S_NEXT: begin
          ram_q   <= ram_adv;
          idx_q   <= '0;
          first_q <= 1'b0;
          if (rem_q == '0) begin
            rb_q    <= small_q ? (8'h7F - {5'b0, mis0_q}) : 8'h7F;
            state_q <= S_DONE;
          end else begin
            state_q <= S_PLAN;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  a_r11_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_valid && !ram_wr_ready |=>
      ram_wr_valid && $stable(ram_wr_addr) && $stable(ram_wr_data));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);
  a_r7_later_blocks_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PLAN && !first_q) |-> (ram_q[2:0] == 3'd0));
  a_r3_rest_even: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PLAN && !first_q) |-> !rem_q[0]);
endmodule

// File: tb/test_cartdma_top.sv
module test_cartdma_top;
  localparam int ROMSZ = 3001;
  localparam int MEMSZ = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] cart_addr_i = '0;
  logic [23:0] ram_addr_i = '0;
  logic [23:0] len_m1_i = '0;
  logic        busy_o, done_o;
  logic [31:0] cart_addr_o;
  logic [23:0] ram_addr_o;
  logic [7:0]  wr_len_rb_o;
  logic        rom_req_valid;
  logic        rom_req_ready = 1'b0;
  logic [31:0] rom_req_addr;
  logic        rom_rsp_valid = 1'b0;
  logic [15:0] rom_rsp_data = '0;
  logic        ram_wr_valid;
  logic        ram_wr_ready = 1'b0;
  logic [23:0] ram_wr_addr;
  logic [7:0]  ram_wr_data;

  always #4 clk = ~clk;

  cartdma_top #(.ROM_BYTES(33'(ROMSZ))) i_cartdma_top (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cart_addr_i(cart_addr_i),
    .ram_addr_i(ram_addr_i), .len_m1_i(len_m1_i), .busy_o(busy_o),
    .done_o(done_o), .cart_addr_o(cart_addr_o), .ram_addr_o(ram_addr_o),
    .wr_len_rb_o(wr_len_rb_o), .rom_req_valid(rom_req_valid),
    .rom_req_ready(rom_req_ready), .rom_req_addr(rom_req_addr),
    .rom_rsp_valid(rom_rsp_valid), .rom_rsp_data(rom_rsp_data),
    .ram_wr_valid(ram_wr_valid), .ram_wr_ready(ram_wr_ready),
    .ram_wr_addr(ram_wr_addr), .ram_wr_data(ram_wr_data)
  );

  int n_chk = 0, n_fail = 0;
  int oor_reqs = 0, got_cnt = 0;
  bit exp_wr [MEMSZ];
  bit got_wr [MEMSZ];
  logic [7:0] exp_d [MEMSZ];
  logic [7:0] got_d [MEMSZ];
  bit rom_pend = 0;
  int rom_dly = 0;
  logic [31:0] rom_paddr = '0;

  function automatic logic [7:0] raw_byte(input int a);
    return 8'((a * 7) + (a >> 8));
  endfunction

  function automatic logic [7:0] rom_byte(input int a);
    return (a >= ROMSZ) ? 8'hFF : raw_byte(a);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ROM and RAM responders: all decisions taken at the falling edge
  always @(negedge clk) begin
    rom_rsp_valid = 1'b0;
    rom_req_ready = ($urandom % 4) != 0;
    ram_wr_ready  = ($urandom % 3) != 0;
    if (rom_pend) begin
      if (rom_dly == 0) begin
        rom_rsp_valid = 1'b1;
        rom_rsp_data  = {raw_byte(int'(rom_paddr)), raw_byte(int'(rom_paddr) + 1)};
        rom_pend = 0;
      end else rom_dly--;
    end
    if (rom_req_valid && int'(rom_req_addr) >= ROMSZ) oor_reqs++;
    if (!rom_pend && rom_req_valid && rom_req_ready) begin
      rom_pend  = 1;
      rom_paddr = rom_req_addr;
      rom_dly   = $urandom % 3;
    end
    if (ram_wr_valid && ram_wr_ready && int'(ram_wr_addr) < MEMSZ) begin
      got_cnt++;
      got_wr[ram_wr_addr] = 1;
      got_d[ram_wr_addr]  = ram_wr_data;
    end
  end

  task automatic model(input int cart0, input int ram0, input int len,
                       output int cart_f, output int ram_f, output int rb, output int nwr);
    int cart = cart0 & ~1;
    int ram  = ram0 & ~1;
    int rem  = len;
    int mis0 = ram & 7;
    bit first = 1;
    nwr = 0;
    while (rem > 0) begin
      int mis = ram & 7;
      int bl = 128 - mis;
      int take = (rem < bl) ? rem : bl;
      int wr;
      rem -= take;
      if (rem % 2 != 0) rem++;
      wr = take;
      if (first) begin
        if (take == bl - 1) wr++;
        wr -= mis;
        if (wr < 0) wr = 0;
      end
      for (int i = 0; i < wr; i++) begin
        exp_wr[ram + i] = 1;
        exp_d[ram + i]  = rom_byte(cart + i);
        nwr++;
      end
      cart += (take + 1) & ~1;
      ram = (ram + wr + 7) & ~7;
      first = 0;
    end
    cart_f = cart; ram_f = ram;
    rb = (len <= 8) ? 127 - mis0 : 127;
  endtask

  task automatic run_xfer(input int cart0, input int ram0, input int len,
                          input bit junk_start, input bit start_at_done);
    int ecart, eram, erb, enwr, cyc, bad;
    for (int i = 0; i < MEMSZ; i++) begin
      exp_wr[i] = 0; got_wr[i] = 0;
    end
    got_cnt = 0;
    model(cart0, ram0, len, ecart, eram, erb, enwr);
    @(negedge clk);
    cart_addr_i = 32'(cart0); ram_addr_i = 24'(ram0); len_m1_i = 24'(len - 1);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R1 busy after start", busy_o, 1);
    cyc = 0;
    while (!done_o && cyc < 6000) begin
      if (junk_start && cyc == 20) begin
        cart_addr_i = 32'h100; ram_addr_i = 24'h3; len_m1_i = 24'd5; start_i = 1'b1;
      end else start_i = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    check("R10 done reached", done_o, 1);
    check("R4 final cartridge address", cart_addr_o, ecart);
    check("R7 final RAM address", ram_addr_o, eram);
    check("R9 length readback", wr_len_rb_o, erb);
    bad = 0;
    for (int i = 0; i < MEMSZ; i++) begin
      if (exp_wr[i] != got_wr[i]) bad++;
      else if (exp_wr[i] && exp_d[i] != got_d[i]) bad++;
    end
    check("R2 R5 R6 R8 written bytes mismatching", bad, 0);
    check("R11 RAM write count", got_cnt, enwr);
    if (start_at_done) begin
      cart_addr_i = 32'h40; ram_addr_i = 24'h10; len_m1_i = 24'd3; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check("R1 start in done cycle ignored (busy)", busy_o, 0);
      check("R1 start in done cycle ignored (ram addr)", ram_addr_o, eram);
    end else begin
      @(negedge clk);
      check("R10 busy falls after done", busy_o, 0);
    end
  endtask

  initial begin
    #(200000 * 8);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=complete");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2417));
    repeat (3) @(negedge clk);
    check("R9 reset readback", wr_len_rb_o, 8'h7F);
    check("R10 reset done", done_o, 0);
    check("R1 reset busy", busy_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corner cases
    run_xfer(0,    0,    1,   0, 0);  // single byte, aligned
    run_xfer(10,   6,    121, 0, 0);  // R5 off-by-one case then R6 cut
    run_xfer(20,   6,    3,   0, 0);  // R6 clamp to zero
    run_xfer(31,   3,    8,   0, 1);  // R1 odd addresses, R9 short readback, done-cycle start
    run_xfer(100,  64,   128, 0, 0);  // one full aligned block
    run_xfer(200,  4,    300, 1, 0);  // multi-block, junk start mid-way
    run_xfer(2990, 512,  40,  0, 0);  // R8 run past ROM end (odd size)
    run_xfer(3100, 1000, 17,  0, 0);  // R8 wholly beyond ROM
    run_xfer(0,    2,    125, 0, 0);  // R5 at misalign 2
    // constrained random
    for (int t = 0; t < 14; t++) begin
      int c = $urandom % 3400;
      int r = $urandom % 2048;
      int l = 1 + ($urandom % 600);
      run_xfer(c, r, l, bit'($urandom % 2), bit'($urandom % 2));
    end
    check("R8 no request beyond ROM", oor_reqs, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule